// File: doc/BRIEF.md
# Rename and In-Order Retirement Buffer

This block renames the registers of a group of micro-ops and holds them in a circular buffer until they can commit in program order. Up to `LANES` micro-ops are offered each cycle. Each one names two architectural sources and, optionally, one architectural destination. Every accepted micro-op receives a buffer entry number. That number is also its physical register. An alias table keeps, for each architectural register, a record of whether its newest value sits in the committed register file or in one particular buffer entry.

For every source, the block answers in the same cycle. It returns the committed value, or the result already written back into a buffer entry, or the number of the entry that will produce the value later. The lookup uses the state at the start of the cycle. A single write-back port marks an entry complete and stores its result, a fault flag and a misprediction flag.

On every cycle, up to `LANES` of the oldest entries leave the buffer in order. Each one copies its result into the committed file. An entry that reaches the retirement window with a fault or misprediction does not commit. Instead it discards itself and every younger entry, and it points the whole alias table back at the committed file.

Top module: `rrb_rename_retire`

## Requirements
- R1: Entries are handed out in program order from a circular tail pointer modulo `N_ENT`, starting at 0 after reset. The k-th valid lane (counting from lane 0, k from 0) gets entry `(tail + k) mod N_ENT` on `alloc_tag`.
- R2: An offered group is taken whole or not at all. `alloc_ready` is 1 exactly when no flush occurs this cycle and the number of free entries at the start of the cycle is at least the number of set `in_valid` bits.
- R3: A source whose alias points at the committed file returns `ready`=1 with the committed value.
- R4: A source whose alias points at a buffer entry returns that entry number on the tag output. If the entry has already been written back, it also returns `ready`=1 with the entry's result. Otherwise it returns `ready`=0.
- R5: Within one group, a source of lane l that names the destination of an earlier valid lane j<l returns `ready`=0 and the tag of the latest such lane. This takes priority over the alias table.
- R6: An accepted micro-op with a destination makes the alias of that register point at its entry. When several lanes write one register, the highest lane wins.
- R7: A write-back to an allocated entry marks it complete, with its result and its fault and misprediction flags, from the next cycle on.
- R8: Each cycle, the oldest entries retire in order as a prefix of lanes: `ret_valid` bit i refers to the i-th oldest entry. An entry retires only if it is complete and clean, and all older entries in the window also retire. `ret_wr`, `ret_dst` and `ret_data` report commits to the file, and the committed file holds the new value from the next cycle.
- R9: When a retiring entry is still the alias of its destination and no accepted micro-op of the same cycle rewrites it, the alias returns to the committed file.
- R10: When the oldest non-retiring entry in the window is complete with a fault or misprediction, `flush` is 1 for that cycle. That entry and all younger entries are discarded, every alias points at the committed file, allocation is refused that cycle, and nothing retires on the next cycle.
- R11: After reset, the buffer is empty, every committed register reads 0 and is ready, nothing retires, and `alloc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Lane carries a micro-op |
| in_has_dst | input | LANES | Lane writes a destination |
| in_dst | input | LANES*AR_W | Destination register per lane |
| in_src_a | input | LANES*AR_W | First source register per lane |
| in_src_b | input | LANES*AR_W | Second source register per lane |
| alloc_ready | output | 1 | Offered group accepted this cycle |
| alloc_tag | output | LANES*TAG_W | Entry number per lane |
| src_a_ready | output | LANES | First source value available |
| src_a_val | output | LANES*DATA_W | First source value |
| src_a_tag | output | LANES*TAG_W | First source producing entry |
| src_b_ready | output | LANES | Second source value available |
| src_b_val | output | LANES*DATA_W | Second source value |
| src_b_tag | output | LANES*TAG_W | Second source producing entry |
| wb_valid | input | 1 | Write-back strobe |
| wb_tag | input | TAG_W | Entry being completed |
| wb_data | input | DATA_W | Result |
| wb_fault | input | 1 | Entry raised an exception |
| wb_mispred | input | 1 | Entry is a mispredicted branch |
| ret_valid | output | LANES | Retiring entries, oldest in lane 0 |
| ret_wr | output | LANES | Retiring entry writes the file |
| ret_dst | output | LANES*AR_W | Register written per retire lane |
| ret_data | output | LANES*DATA_W | Value written per retire lane |
| flush | output | 1 | Discard of the whole buffer this cycle |

## Verification
The bench builds the block with ten entries, four lanes, eight architectural registers and 16-bit data. With ten entries, a full buffer and refused groups come up within a few cycles. Because ten is not a power of two, the pointers wrap through a modulo that is not a plain bit mask. Eight registers shared by four lanes make same-group destination collisions and in-group forwarding frequent. A phase with write-back held off forces long stalls. A later phase injects faults and mispredictions so that flushes land with partial retirement in the same window.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    // State of one slot of the retirement window, as seen by the picker
    typedef struct packed {
        logic present;
        logic done;
        logic fault;
        logic mispred;
    } ret_flags_t;

endpackage

// File: rtl/rrb_lane_slots.sv
// Prefix count of valid lanes: slot offset of each lane within the group.
module rrb_lane_slots #(
    parameter int LANES = 4,
    localparam int LN_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]      valid,
    output logic [LANES*LN_W-1:0] offset,
    output logic [LN_W-1:0]       total
);
    always_comb begin
        logic [LN_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            offset[i*LN_W +: LN_W] = acc;
            acc = acc + LN_W'(valid[i]);
        end
        total = acc;
    end
endmodule

// File: rtl/rrb_retire_pick.sv
// Chooses the in-order retiring prefix of the window and detects a flush.
module rrb_retire_pick #(
    parameter int LANES = 4
) (
    input  rrb_pkg::ret_flags_t [LANES-1:0] flags,
    output logic [LANES-1:0]                take,
    output logic                            flush
);
    always_comb begin
        logic open;
        open  = 1'b1;
        take  = '0;
        flush = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (open && flags[i].present && flags[i].done) begin
                if (flags[i].fault || flags[i].mispred) begin
                    flush = 1'b1;
                    open  = 1'b0;
                end else begin
                    take[i] = 1'b1;
                end
            end else begin
                open = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rrb_rename_retire.sv
module rrb_rename_retire #(
    parameter int N_ENT  = 40,
    parameter int LANES  = 4,
    parameter int N_ARCH = 8,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(N_ENT),
    localparam int AR_W  = $clog2(N_ARCH),
    localparam int CNT_W = $clog2(N_ENT + 1),
    localparam int LN_W  = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         in_valid,
    input  logic [LANES-1:0]         in_has_dst,
    input  logic [LANES*AR_W-1:0]    in_dst,
    input  logic [LANES*AR_W-1:0]    in_src_a,
    input  logic [LANES*AR_W-1:0]    in_src_b,
    output logic                     alloc_ready,
    output logic [LANES*TAG_W-1:0]   alloc_tag,
    output logic [LANES-1:0]         src_a_ready,
    output logic [LANES*DATA_W-1:0]  src_a_val,
    output logic [LANES*TAG_W-1:0]   src_a_tag,
    output logic [LANES-1:0]         src_b_ready,
    output logic [LANES*DATA_W-1:0]  src_b_val,
    output logic [LANES*TAG_W-1:0]   src_b_tag,
    input  logic                     wb_valid,
    input  logic [TAG_W-1:0]         wb_tag,
    input  logic [DATA_W-1:0]        wb_data,
    input  logic                     wb_fault,
    input  logic                     wb_mispred,
    output logic [LANES-1:0]         ret_valid,
    output logic [LANES-1:0]         ret_wr,
    output logic [LANES*AR_W-1:0]    ret_dst,
    output logic [LANES*DATA_W-1:0]  ret_data,
    output logic                     flush
);

    typedef struct packed {
        logic              ev;
        logic              dv;
        logic              fault;
        logic              mispred;
        logic              has_dst;
        logic [AR_W-1:0]   dst;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef struct packed {
        logic             in_buf;
        logic [TAG_W-1:0] tag;
    } map_t;

    typedef struct packed {
        ent_t [N_ENT-1:0]                rob;
        map_t [N_ARCH-1:0]               rat;
        logic [N_ARCH-1:0][DATA_W-1:0]   rrf;
        logic [TAG_W-1:0]                head;
        logic [TAG_W-1:0]                tail;
        logic [CNT_W-1:0]                count;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [TAG_W-1:0] wrap_add(logic [TAG_W-1:0] a, logic [LN_W-1:0] b);
        logic [TAG_W:0] s;
        s = {1'b0, a} + (TAG_W+1)'(b);
        if (s >= (TAG_W+1)'(N_ENT)) s = s - (TAG_W+1)'(N_ENT);
        return s[TAG_W-1:0];
    endfunction

    // ---- group slot offsets (R1) ----
    logic [LANES*LN_W-1:0] lane_off;
    logic [LN_W-1:0]       n_in;

    rrb_lane_slots #(.LANES(LANES)) u_slots (
        .valid  (in_valid),
        .offset (lane_off),
        .total  (n_in)
    );

    logic [LANES-1:0][TAG_W-1:0] lane_tag;
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_tag[l] = wrap_add(st_q.tail, lane_off[l*LN_W +: LN_W]);
            alloc_tag[l*TAG_W +: TAG_W] = lane_tag[l];
        end
    end

    // ---- retirement window (R8, R10) ----
    rrb_pkg::ret_flags_t [LANES-1:0] r_flags;
    logic [LANES-1:0][TAG_W-1:0]     r_idx;
    logic [LANES-1:0]                r_take;
    logic                            r_flush;
    logic [LN_W-1:0]                 n_ret;

    always_comb begin
        n_ret = '0;
        for (int i = 0; i < LANES; i++) begin
            r_idx[i]           = wrap_add(st_q.head, LN_W'(i));
            r_flags[i].present = CNT_W'(i) < st_q.count;
            r_flags[i].done    = st_q.rob[r_idx[i]].dv;
            r_flags[i].fault   = st_q.rob[r_idx[i]].fault;
            r_flags[i].mispred = st_q.rob[r_idx[i]].mispred;
        end
        for (int i = 0; i < LANES; i++) n_ret = n_ret + LN_W'(r_take[i]);
    end

    rrb_retire_pick #(.LANES(LANES)) u_pick (
        .flags (r_flags),
        .take  (r_take),
        .flush (r_flush)
    );

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            ret_wr[i]                    = r_take[i] && st_q.rob[r_idx[i]].has_dst;
            ret_dst[i*AR_W +: AR_W]      = st_q.rob[r_idx[i]].dst;
            ret_data[i*DATA_W +: DATA_W] = st_q.rob[r_idx[i]].data;
        end
    end
    assign ret_valid = r_take;
    assign flush     = r_flush;

    // ---- admission (R2) ----
    logic [CNT_W-1:0] n_free;
    logic             fire;
    assign n_free      = CNT_W'(N_ENT) - st_q.count;
    assign alloc_ready = !r_flush && (CNT_W'(n_in) <= n_free);
    assign fire        = alloc_ready && (|in_valid);

    // ---- source resolution (R3, R4, R5) ----
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            for (int s = 0; s < 2; s++) begin
                logic [AR_W-1:0]   arch;
                logic              hit;
                logic [TAG_W-1:0]  t;
                logic              rdy;
                logic [DATA_W-1:0] v;
                arch = (s == 0) ? in_src_a[l*AR_W +: AR_W] : in_src_b[l*AR_W +: AR_W];
                hit  = 1'b0;
                t    = '0;
                for (int j = 0; j < l; j++) begin
                    if (in_valid[j] && in_has_dst[j] && in_dst[j*AR_W +: AR_W] == arch) begin
                        hit = 1'b1;
                        t   = lane_tag[j];
                    end
                end
                if (hit) begin
                    rdy = 1'b0;
                    v   = '0;
                end else if (st_q.rat[arch].in_buf) begin
                    t   = st_q.rat[arch].tag;
                    rdy = st_q.rob[t].dv;
                    v   = st_q.rob[t].dv ? st_q.rob[t].data : '0;
                end else begin
                    rdy = 1'b1;
                    v   = st_q.rrf[arch];
                end
                if (s == 0) begin
                    src_a_ready[l]                = rdy;
                    src_a_val[l*DATA_W +: DATA_W] = v;
                    src_a_tag[l*TAG_W +: TAG_W]   = t;
                end else begin
                    src_b_ready[l]                = rdy;
                    src_b_val[l*DATA_W +: DATA_W] = v;
                    src_b_tag[l*TAG_W +: TAG_W]   = t;
                end
            end
        end
    end

    // ---- next state ----
    always_comb begin
        st_d = st_q;
        // commit (R8) and alias release (R9)
        for (int i = 0; i < LANES; i++) begin
            if (r_take[i]) begin
                if (st_q.rob[r_idx[i]].has_dst) begin
                    st_d.rrf[st_q.rob[r_idx[i]].dst] = st_q.rob[r_idx[i]].data;
                    if (st_q.rat[st_q.rob[r_idx[i]].dst].in_buf &&
                        st_q.rat[st_q.rob[r_idx[i]].dst].tag == r_idx[i])
                        st_d.rat[st_q.rob[r_idx[i]].dst].in_buf = 1'b0;
                end
                st_d.rob[r_idx[i]].ev = 1'b0;
                st_d.rob[r_idx[i]].dv = 1'b0;
            end
        end
        st_d.head  = wrap_add(st_q.head, n_ret);
        st_d.count = st_q.count - CNT_W'(n_ret);
        // write-back (R7)
        if (wb_valid && st_q.rob[wb_tag].ev) begin
            st_d.rob[wb_tag].dv      = 1'b1;
            st_d.rob[wb_tag].data    = wb_data;
            st_d.rob[wb_tag].fault   = wb_fault;
            st_d.rob[wb_tag].mispred = wb_mispred;
        end
        if (r_flush) begin
            // discard everything left (R10)
            for (int e = 0; e < N_ENT; e++) begin
                st_d.rob[e].ev = 1'b0;
                st_d.rob[e].dv = 1'b0;
            end
            for (int r = 0; r < N_ARCH; r++) st_d.rat[r].in_buf = 1'b0;
            st_d.head  = st_q.tail;
            st_d.count = '0;
        end else if (fire) begin
            // allocation and alias update (R1, R6)
            for (int l = 0; l < LANES; l++) begin
                if (in_valid[l]) begin
                    st_d.rob[lane_tag[l]] = '{ev: 1'b1, dv: 1'b0, fault: 1'b0, mispred: 1'b0,
                                             has_dst: in_has_dst[l],
                                             dst: in_dst[l*AR_W +: AR_W], data: '0};
                    if (in_has_dst[l])
                        st_d.rat[in_dst[l*AR_W +: AR_W]] = '{in_buf: 1'b1, tag: lane_tag[l]};
                end
            end
            st_d.tail  = wrap_add(st_q.tail, n_in);
            st_d.count = st_d.count + CNT_W'(n_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rrb_checker.sv
module rrb_checker #(
    parameter int N_ENT = 40,
    parameter int LANES = 4,
    parameter int TAG_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       in_valid,
    input logic                   alloc_ready,
    input logic [LANES*TAG_W-1:0] alloc_tag,
    input logic [LANES-1:0]       ret_valid,
    input logic [LANES-1:0]       ret_wr,
    input logic                   flush
);
    int  occ;
    int  tail;
    logic fire;
    assign fire = alloc_ready && (|in_valid);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ  <= 0;
            tail <= 0;
        end else begin
            if (flush) occ <= 0;
            else occ <= occ - $countones(ret_valid) + (fire ? $countones(in_valid) : 0);
            if (fire) tail <= (tail + $countones(in_valid)) % N_ENT;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (occ + $countones(in_valid) <= N_ENT));

    assert_tag_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_valid[0]) |-> (alloc_tag[TAG_W-1:0] == TAG_W'(tail)));

    assert_ret_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((ret_valid + 1'b1) & ret_valid) == '0));

    assert_ret_wr_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_wr & ~ret_valid) == '0));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ret_valid == '0));

endmodule

bind rrb_rename_retire rrb_checker #(.N_ENT(N_ENT), .LANES(LANES), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .alloc_ready (alloc_ready),
    .alloc_tag   (alloc_tag),
    .ret_valid   (ret_valid),
    .ret_wr      (ret_wr),
    .flush       (flush)
);

// File: tb/sim_rrb_rename_retire.sv
module sim_rrb_rename_retire;
    localparam int N_ENT = 10, LANES = 4, N_ARCH = 8, DW = 16;
    localparam int TW = $clog2(N_ENT), AW = $clog2(N_ARCH);

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic [LANES-1:0] in_valid = '0, in_has_dst = '0;
    logic [LANES*AW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic alloc_ready, flush;
    logic [LANES*TW-1:0] alloc_tag, src_a_tag, src_b_tag;
    logic [LANES-1:0] src_a_ready, src_b_ready, ret_valid, ret_wr;
    logic [LANES*DW-1:0] src_a_val, src_b_val, ret_data;
    logic [LANES*AW-1:0] ret_dst;
    logic wb_valid = 0, wb_fault = 0, wb_mispred = 0;
    logic [TW-1:0] wb_tag = '0;
    logic [DW-1:0] wb_data = '0;

    rrb_rename_retire #(.N_ENT(N_ENT), .LANES(LANES), .N_ARCH(N_ARCH), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_has_dst(in_has_dst),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .src_a_ready(src_a_ready), .src_a_val(src_a_val), .src_a_tag(src_a_tag),
        .src_b_ready(src_b_ready), .src_b_val(src_b_val), .src_b_tag(src_b_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .wb_fault(wb_fault), .wb_mispred(wb_mispred),
        .ret_valid(ret_valid), .ret_wr(ret_wr), .ret_dst(ret_dst), .ret_data(ret_data),
        .flush(flush));

    typedef struct {
        int tag; bit has_dst; int dst; bit done; bit fault; bit mis; logic [DW-1:0] data;
    } m_ent_t;

    m_ent_t q[$];
    bit rat_in[N_ARCH];
    int rat_tag[N_ARCH];
    logic [DW-1:0] rrf[N_ARCH];
    int tail = 0;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one cycle of stimulus; wb chosen among pending model entries
    task automatic drive(int p_in, int p_wb, int p_bad);
        int cand[$];
        for (int l = 0; l < LANES; l++) begin
            in_valid[l]   = ($urandom % 100) < p_in;
            in_has_dst[l] = ($urandom % 4) != 0;
            in_dst[l*AW +: AW]   = AW'($urandom % N_ARCH);
            in_src_a[l*AW +: AW] = AW'($urandom % N_ARCH);
            in_src_b[l*AW +: AW] = AW'($urandom % N_ARCH);
        end
        foreach (q[i]) if (!q[i].done) cand.push_back(q[i].tag);
        wb_valid = 0; wb_fault = 0; wb_mispred = 0;
        if (cand.size() > 0 && ($urandom % 100) < p_wb) begin
            wb_valid   = 1;
            wb_tag     = TW'(cand[$urandom % cand.size()]);
            wb_data    = DW'($urandom);
            wb_fault   = ($urandom % 100) < p_bad;
            wb_mispred = !wb_fault && (($urandom % 100) < p_bad);
        end
    endtask

    task automatic check_source(int l, int s);
        int arch, hit_tag, e;
        bit hit;
        logic rdy; logic [DW-1:0] v; logic [TW-1:0] t;
        arch = (s == 0) ? int'(in_src_a[l*AW +: AW]) : int'(in_src_b[l*AW +: AW]);
        rdy = (s == 0) ? src_a_ready[l] : src_b_ready[l];
        v   = (s == 0) ? src_a_val[l*DW +: DW] : src_b_val[l*DW +: DW];
        t   = (s == 0) ? src_a_tag[l*TW +: TW] : src_b_tag[l*TW +: TW];
        hit = 0; hit_tag = 0;
        begin
            int k = 0;
            for (int j = 0; j < LANES; j++) begin
                if (j < l && in_valid[j] && in_has_dst[j] && int'(in_dst[j*AW +: AW]) == arch) begin
                    hit = 1; hit_tag = (tail + k) % N_ENT;
                end
                if (in_valid[j]) k++;
            end
        end
        if (hit) begin
            chk("R5", "bypass ready", rdy, 0);
            chk("R5", "bypass tag", t, hit_tag);
        end else if (rat_in[arch]) begin
            e = -1;
            foreach (q[i]) if (q[i].tag == rat_tag[arch]) e = i;
            chk("R4 R6", "buffer tag", t, rat_tag[arch]);
            if (e >= 0 && q[e].done) begin
                chk("R4 R7", "buffer ready", rdy, 1);
                chk("R4 R7", "buffer value", v, q[e].data);
            end else chk("R4 R6", "pending ready", rdy, 0);
        end else begin
            chk("R3 R9", "committed ready", rdy, 1);
            chk("R3 R8", "committed value", v, rrf[arch]);
        end
    endtask

    task automatic step();
        int nv, nret, k;
        bit fl, exp_rdy;
        nv = $countones(in_valid);
        nret = 0; fl = 0;
        for (int i = 0; i < LANES && i < q.size(); i++) begin
            if (!q[i].done) break;
            if (q[i].fault || q[i].mis) begin fl = 1; break; end
            nret++;
        end
        chk("R8", "ret_valid", ret_valid, (1 << nret) - 1);
        chk("R10", "flush", flush, fl);
        for (int i = 0; i < nret; i++) begin
            chk("R8", "ret_wr", ret_wr[i], q[i].has_dst);
            if (q[i].has_dst) begin
                chk("R8", "ret_dst", ret_dst[i*AW +: AW], q[i].dst);
                chk("R7 R8", "ret_data", ret_data[i*DW +: DW], q[i].data);
            end
        end
        exp_rdy = !fl && ((N_ENT - q.size()) >= nv);
        chk(fl ? "R10" : "R2", "alloc_ready", alloc_ready, exp_rdy);
        k = 0;
        for (int l = 0; l < LANES; l++) begin
            if (in_valid[l]) begin
                chk("R1", "alloc_tag", alloc_tag[l*TW +: TW], (tail + k) % N_ENT);
                check_source(l, 0);
                check_source(l, 1);
                k++;
            end
        end
        // state update
        for (int i = 0; i < nret; i++) begin
            m_ent_t e = q.pop_front();
            if (e.has_dst) begin
                rrf[e.dst] = e.data;
                if (rat_in[e.dst] && rat_tag[e.dst] == e.tag) rat_in[e.dst] = 0;
            end
        end
        if (wb_valid) foreach (q[i]) if (q[i].tag == int'(wb_tag)) begin
            q[i].done = 1; q[i].data = wb_data; q[i].fault = wb_fault; q[i].mis = wb_mispred;
        end
        if (fl) begin
            q.delete();
            foreach (rat_in[r]) rat_in[r] = 0;
        end else if (exp_rdy && nv > 0) begin
            for (int l = 0; l < LANES; l++) if (in_valid[l]) begin
                m_ent_t e;
                e.tag = tail; e.has_dst = in_has_dst[l]; e.dst = int'(in_dst[l*AW +: AW]);
                e.done = 0; e.fault = 0; e.mis = 0; e.data = '0;
                q.push_back(e);
                if (e.has_dst) begin rat_in[e.dst] = 1; rat_tag[e.dst] = e.tag; end
                tail = (tail + 1) % N_ENT;
            end
        end
    endtask

    initial begin
        foreach (rrf[r]) begin rrf[r] = '0; rat_in[r] = 0; rat_tag[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R11: reset state observed at the ports
        chk("R11", "alloc_ready", alloc_ready, 1);
        chk("R11", "ret_valid", ret_valid, 0);
        chk("R11", "flush", flush, 0);
        for (int l = 0; l < LANES; l++) begin
            chk("R11", "src ready", src_a_ready[l], 1);
            chk("R11", "src value", src_a_val[l*DW +: DW], 0);
        end
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (c < 60)        drive(70, 0, 0);    // no write-back: fill and stall
            else if (c < 1500) drive(60, 80, 0);   // clean flow
            else               drive(60, 70, 6);   // faults and mispredictions
            #1;
            step();
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule